// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Controller

This block is the command half of a serial flash slave, limited to block erase and the status traffic around it. While chip select is low it collects an 8-bit opcode and a 24-bit address from the serial input. Each bit is taken on a rising serial-clock edge, most significant bit first. The serial pins are sampled by the block's own system clock, so the serial clock must stay well below it.

When chip select goes high again, the block judges the frame and either starts an erase or rejects it. The erase can be 4 KB, 32 KB or 64 KB. A frame is rejected for three reasons:
- the address is incomplete;
- the write-enable latch is clear;
- any protection bit is set for a 16 KB physical sector that the span touches.

Every rejection of a write-enabled erase clears the write-enable latch. An accepted erase sets busy for a fixed number of clock cycles. The erase-verify result comes in on a pass/fail input and is recorded as an erase-error bit. Status can be read at any time, including while an erase runs.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: The frame format and status read work as follows.
  - A frame of opcode 0x06 sets the write-enable latch.
  - Opcode 0x05 returns the status byte on `spiMiso`, MSB first. Each bit is updated on a falling serial-clock edge and is valid at the next rising edge. The byte is refreshed every 8 bits while chip select stays low.
  - Status bit 0 is busy, bit 1 is write-enable and bit 5 is erase-error. All other status bits read 0.
- R3: The erase opcodes and address handling are as follows.
  - Opcode 0x20 erases 4 KB, 0x52 erases 32 KB and 0xD8 erases 64 KB.
  - The 24 address bits follow the opcode, MSB first.
  - The span base is the address with its low 12, 15 or 16 bits cleared. Only the low `ADDR_BITS` (19) address bits select a location.
- R4: An erase frame received while write-enable is 0 changes no status bit.
- R5: If chip select rises after the erase opcode but before all 24 address bits, the erase does not start and write-enable is cleared.
- R6: Protection is checked per sector and covers the whole span.
  - Bit i of `sectorProt` protects sector i, the 16 KB region at i·16 KB.
  - If any protected sector lies inside the span, the erase does not start and write-enable is cleared.
- R7: An accepted erase sets busy and clears write-enable on the same clock edge.
- R8: Busy stays high for exactly `ERASE_CYCLES` clock cycles. Status reads during that time return busy = 1.
- R9: When busy falls, erase-error takes the value `eraseFail` had in the last busy cycle. A passing erase clears it.
- R10: While busy, every opcode other than the status read is ignored. This includes 0x06.
- R11: `spiMisoOe` is 0 while `spiCsN` is high and 1 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiCsN | input | 1 | Serial chip select, active low |
| spiClk | input | 1 | Serial clock (idle low) |
| spiMosi | input | 1 | Serial data in |
| sectorProt | input | NSECT (32) | Per-sector protection, one bit per 16 KB sector |
| eraseFail | input | 1 | Erase-verify result, 1 = a byte failed to erase |
| spiMiso | output | 1 | Serial data out |
| spiMisoOe | output | 1 | Output enable for the `spiMiso` pad driver |

## Verification
The bench protects sector 3 only and then tries spans that straddle it from different sides:
- a 32 KB erase at 0x008000;
- a 64 KB erase at 0x000000;
- a 4 KB erase inside the sector;
- a 64 KB address that aliases onto the sector through bits above the array.

It also runs an accepted 32 KB erase of the neighbouring pair, sectors 0 and 1. A design that checks only the addressed sector would start an erase it should refuse, and the first poll would show busy. A design that leaves write-enable set on an abort would read 0x02 instead of 0x00.

Short-address frames, erases without write-enable, a write-enable sent during busy, and an erase that fails verify followed by one that passes each target one status bit.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_STAT_READ = 8'h05;
  localparam logic [7:0] OP_ERASE_4K  = 8'h20;
  localparam logic [7:0] OP_ERASE_32K = 8'h52;
  localparam logic [7:0] OP_ERASE_64K = 8'hD8;

  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_EERR = 5;

  // Frame summary the datapath hands to the control
  typedef struct packed {
    logic       frameDone;
    logic       opDone;
    logic       addrDone;
    logic [7:0] opcode;
    logic       spanProt;
  } frameInfo_t;

  // Strobes and status from control to datapath
  typedef struct packed {
    logic [7:0] statusByte;
  } ctrlToDp_t;

  function automatic logic isEraseOp(input logic [7:0] op);
    return (op == OP_ERASE_4K) || (op == OP_ERASE_32K) || (op == OP_ERASE_64K);
  endfunction
endpackage

// File: rtl/fe_datapath.sv
module fe_datapath
  import fe_pkg::*;
#(
  parameter int ADDR_BITS = 19,
  parameter int SECT_LOG2 = 14,
  localparam int NSECT = 1 << (ADDR_BITS - SECT_LOG2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiCsN,
  input  logic             spiClk,
  input  logic             spiMosi,
  input  logic [NSECT-1:0] sectorProt,
  input  ctrlToDp_t        fromCtrl,
  output frameInfo_t       info,
  output logic             spiMiso
);
  localparam int CNT_W      = 6;
  localparam int OP_BITS    = 8;
  localparam int FRAME_BITS = 32;
  localparam logic [CNT_W-1:0] OP_END    = CNT_W'(OP_BITS);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);

  logic sckQ, sckQQ, csNQ, csNQQ, mosiQ;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]  opReg;
  logic [23:0] addrReg;
  logic [7:0]  misoSh;
  logic [2:0]  misoCnt;
  logic        misoOut;

  logic sckRise, sckFall, frameEnd, opDone, addrDone;
  assign sckRise  = sckQ & ~sckQQ & ~csNQ;
  assign sckFall  = ~sckQ & sckQQ & ~csNQ;
  assign frameEnd = csNQ & ~csNQQ;
  assign opDone   = bitCnt >= OP_END;
  assign addrDone = bitCnt == FRAME_END;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ <= 1'b0; sckQQ <= 1'b0;
      csNQ <= 1'b1; csNQQ <= 1'b1;
      mosiQ <= 1'b0;
      bitCnt <= '0; opReg <= '0; addrReg <= '0;
      misoSh <= '0; misoCnt <= '0; misoOut <= 1'b0;
    end else begin
      sckQ  <= spiClk; sckQQ <= sckQ;
      csNQ  <= spiCsN; csNQQ <= csNQ;
      mosiQ <= spiMosi;
      if (csNQ) begin
        bitCnt  <= '0;
        misoCnt <= '0;
      end else begin
        if (sckRise) begin
          if (bitCnt < OP_END) opReg <= {opReg[6:0], mosiQ};
          else if (bitCnt < FRAME_END) addrReg <= {addrReg[22:0], mosiQ};
          if (bitCnt != FRAME_END) bitCnt <= bitCnt + 1'b1;
        end
        if (sckFall && opDone && opReg == OP_STAT_READ) begin
          if (misoCnt == 3'd0) begin
            misoOut <= fromCtrl.statusByte[7];
            misoSh  <= {fromCtrl.statusByte[6:0], 1'b0};
          end else begin
            misoOut <= misoSh[7];
            misoSh  <= {misoSh[6:0], 1'b0};
          end
          misoCnt <= misoCnt + 1'b1;
        end
      end
    end
  end

  // Span of the addressed erase, in array coordinates
  logic [ADDR_BITS-1:0] arrAddr, spanMask, firstSect, lastSect;
  assign arrAddr = addrReg[ADDR_BITS-1:0];
  always_comb begin
    unique case (opReg)
      OP_ERASE_4K:  spanMask = ADDR_BITS'(12'hFFF);
      OP_ERASE_32K: spanMask = ADDR_BITS'(15'h7FFF);
      OP_ERASE_64K: spanMask = ADDR_BITS'(16'hFFFF);
      default:      spanMask = '0;
    endcase
  end
  assign firstSect = (arrAddr & ~spanMask) >> SECT_LOG2;
  assign lastSect  = (arrAddr | spanMask) >> SECT_LOG2;

  logic [NSECT-1:0] inSpan;
  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    assign inSpan[g] = (ADDR_BITS'(g) >= firstSect) && (ADDR_BITS'(g) <= lastSect);
  end

  assign info.frameDone = frameEnd;
  assign info.opDone    = opDone;
  assign info.addrDone  = addrDone;
  assign info.opcode    = opReg;
  assign info.spanProt  = |(inSpan & sectorProt);
  assign spiMiso        = misoOut;
endmodule

// File: rtl/fe_control.sv
module fe_control
  import fe_pkg::*;
#(
  parameter int ERASE_CYCLES = 200,
  localparam int TMR_W = $clog2(ERASE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  frameInfo_t info,
  input  logic       eraseFail,
  output ctrlToDp_t  toDp
);
  logic busy, wel, eErr;
  logic [TMR_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; wel <= 1'b0; eErr <= 1'b0; timer <= '0;
    end else if (busy) begin
      if (timer == '0) begin
        busy <= 1'b0;
        eErr <= eraseFail;
      end else begin
        timer <= timer - 1'b1;
      end
    end else if (info.frameDone && info.opDone) begin
      if (info.opcode == OP_WR_ENABLE) begin
        wel <= 1'b1;
      end else if (isEraseOp(info.opcode) && wel) begin
        wel <= 1'b0;
        if (info.addrDone && !info.spanProt) begin
          busy  <= 1'b1;
          timer <= TMR_W'(ERASE_CYCLES - 1);
        end
      end
    end
  end

  always_comb begin
    toDp.statusByte = '0;
    toDp.statusByte[BIT_BUSY] = busy;
    toDp.statusByte[BIT_WEL]  = wel;
    toDp.statusByte[BIT_EERR] = eErr;
  end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fe_pkg::*;
#(
  parameter int ADDR_BITS    = 19,
  parameter int SECT_LOG2    = 14,
  parameter int ERASE_CYCLES = 200,
  localparam int NSECT = 1 << (ADDR_BITS - SECT_LOG2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiCsN,
  input  logic             spiClk,
  input  logic             spiMosi,
  input  logic [NSECT-1:0] sectorProt,
  input  logic             eraseFail,
  output logic             spiMiso,
  output logic             spiMisoOe
);
  frameInfo_t info;
  ctrlToDp_t  ctrlBus;

  fe_datapath #(.ADDR_BITS(ADDR_BITS), .SECT_LOG2(SECT_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiClk(spiClk), .spiMosi(spiMosi),
    .sectorProt(sectorProt), .fromCtrl(ctrlBus), .info(info), .spiMiso(spiMiso)
  );

  fe_control #(.ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .info(info), .eraseFail(eraseFail), .toDp(ctrlBus)
  );

  assign spiMisoOe = ~spiCsN;
endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk #(
  parameter int ERASE_CYCLES = 200
) (
  input logic       clk,
  input logic       rstN,
  input logic       frameDone,
  input logic       addrDone,
  input logic       spanProt,
  input logic [7:0] statusByte
);
  logic busy, wel, eErr;
  assign busy = statusByte[0];
  assign wel  = statusByte[1];
  assign eErr = statusByte[5];

  int busyLen;
  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  a_r7_wel_low_when_busy_rises: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !wel);
  a_r7_busy_starts_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(frameDone));
  a_r5_busy_needs_full_address: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(addrDone));
  a_r6_busy_needs_clear_span: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(spanProt));
  a_r2_wel_set_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(frameDone));
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == ERASE_CYCLES);
  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyLen <= ERASE_CYCLES);
  a_r9_eerr_moves_at_completion: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(eErr) |-> $fell(busy));
endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .frameDone(info.frameDone), .addrDone(info.addrDone),
  .spanProt(info.spanProt), .statusByte(ctrlBus.statusByte)
);

// File: tb/flash_erase_ctrl_test.sv
module flash_erase_ctrl_test;
  localparam int ERASE_CYCLES = 200;
  localparam int NSECT = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rstN = 1'b0, spiCsN = 1'b1, spiClk = 1'b0, spiMosi = 1'b0, eraseFail = 1'b0;
  logic [NSECT-1:0] sectorProt = '0;
  logic spiMiso, spiMisoOe;

  flash_erase_ctrl #(.ERASE_CYCLES(ERASE_CYCLES)) uut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiClk(spiClk), .spiMosi(spiMosi),
    .sectorProt(sectorProt), .eraseFail(eraseFail), .spiMiso(spiMiso), .spiMisoOe(spiMisoOe)
  );

  typedef struct { logic [7:0] exp; string req; } expItem_t;
  expItem_t expQ[$];
  logic [7:0] gotByte;
  event byteDone;
  int nVec = 0, nBad = 0;
  bit finished = 0;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiXfer(input logic [7:0] op, input int nAddr, input logic [23:0] addr,
                         input int nRead, output logic [7:0] rd);
    rd = '0;
    spiCsN = 1'b0;
    waitClk(4);
    for (int b = 0; b < 8 + nAddr + nRead; b++) begin
      if (b < 8) spiMosi = op[7-b];
      else if (b < 8 + nAddr) spiMosi = addr[23-(b-8)];
      else spiMosi = 1'b0;
      waitClk(4);
      if (b >= 8 + nAddr) rd = {rd[6:0], spiMiso};
      spiClk = 1'b1;
      waitClk(4);
      spiClk = 1'b0;
    end
    waitClk(4);
    spiCsN = 1'b1;
    waitClk(8);
  endtask

  task automatic cmd(input logic [7:0] op, input int nAddr, input logic [23:0] addr);
    logic [7:0] junk;
    spiXfer(op, nAddr, addr, 0, junk);
  endtask

  // driver: push expected status, then read it
  task automatic expectStatus(input logic [7:0] exp, input string req);
    logic [7:0] rd;
    expItem_t it;
    it.exp = exp; it.req = req;
    expQ.push_back(it);
    spiXfer(8'h05, 0, 24'h0, 8, rd);
    gotByte = rd;
    ->byteDone;
    waitClk(1);
  endtask

  task automatic checkVal(input logic [7:0] got, input logic [7:0] exp, input string req);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic pollIdle(output int polls, output logic [7:0] last);
    polls = 0;
    do begin
      spiXfer(8'h05, 0, 24'h0, 8, last);
      polls++;
    end while (last[0] && polls < 8);
  endtask

  // monitor
  initial begin
    forever begin
      expItem_t it;
      @(byteDone);
      it = expQ.pop_front();
      nVec++;
      if (gotByte !== it.exp) begin
        nBad++;
        $display("FAIL %s: got 0x%02h expected 0x%02h", it.req, gotByte, it.exp);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nVec++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    int polls;
    logic [7:0] last;
    waitClk(6);
    rstN = 1'b1;
    waitClk(4);

    // R11: output enable follows chip select
    checkVal({7'd0, spiMisoOe}, 8'd0, "R11 oe idle");
    spiCsN = 1'b0; waitClk(2);
    checkVal({7'd0, spiMisoOe}, 8'd1, "R11 oe selected");
    spiCsN = 1'b1; waitClk(8);

    expectStatus(8'h00, "R1 reset status");

    // R4: erase without write-enable
    cmd(8'hD8, 24, 24'h000000);
    expectStatus(8'h00, "R4 erase without WEL");

    // R2: write enable
    cmd(8'h06, 0, 24'h0);
    expectStatus(8'h02, "R2 WEL set");

    // R5: incomplete address
    cmd(8'h52, 16, 24'h000000);
    expectStatus(8'h00, "R5 short address clears WEL");

    // R6: protected sector 3 (0x00C000..0x00FFFF)
    sectorProt = 32'h0000_0008;
    cmd(8'h06, 0, 24'h0);
    cmd(8'h52, 24, 24'h008000);
    expectStatus(8'h00, "R6 32K span 2..3 rejected");
    cmd(8'h06, 0, 24'h0);
    cmd(8'hD8, 24, 24'h003000);
    expectStatus(8'h00, "R6 64K span 0..3 rejected");
    cmd(8'h06, 0, 24'h0);
    cmd(8'h20, 24, 24'h00D000);
    expectStatus(8'h00, "R6 4K in sector 3 rejected");
    cmd(8'h06, 0, 24'h0);
    cmd(8'hD8, 24, 24'h08C000);
    expectStatus(8'h00, "R3 upper address bits alias onto sector 3");

    // R3/R7/R8: accepted 32K erase of sectors 0..1
    cmd(8'h06, 0, 24'h0);
    cmd(8'h52, 24, 24'h007FFF);
    expectStatus(8'h01, "R7 busy set, WEL cleared");
    pollIdle(polls, last);
    checkVal(last, 8'h00, "R8 idle after erase");
    checkVal(8'(polls <= 2), 8'd1, "R8 busy ends within duration");

    // R9: failing erase sets erase-error; R10: WEL ignored while busy
    eraseFail = 1'b1;
    cmd(8'h06, 0, 24'h0);
    cmd(8'h20, 24, 24'h010000);
    cmd(8'h06, 0, 24'h0);
    expectStatus(8'h01, "R10 WEL ignored while busy");
    pollIdle(polls, last);
    checkVal(last, 8'h20, "R9 erase-error set");

    // R9: passing erase clears it
    eraseFail = 1'b0;
    cmd(8'h06, 0, 24'h0);
    cmd(8'hD8, 24, 24'h070000);
    expectStatus(8'h21, "R8 busy during second erase");
    pollIdle(polls, last);
    checkVal(last, 8'h00, "R9 erase-error cleared");

    waitClk(4);
    finish();
  end
endmodule